// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the target side of a serial flash interface. It watches chip select and the serial clock and takes a one-byte opcode from lane 0. The opcode decides what follows. A read gets an address phase, an optional run of dummy clocks, and an output phase on one, two or four lanes. A write-type command gets a byte-collecting phase, and a strobe is raised when chip select rises on a byte boundary. Anything else is ignored until chip select goes high again.

The serial inputs are oversampled by the system clock. Address and data pass to and from the storage logic through simple byte strobes: `rd_start` gives the start address of a read, and `rd_next` asks for the next byte. Busy and quad-enable are sampled once, when the opcode completes. That single sample decides whether the command proceeds or is dropped.

Top module: `sfe_cmd_front`

## Requirements
- R1: Opcode, address and data bits are transferred most significant bit first. The opcode is taken from lane 0 on the first eight rising serial-clock edges after chip select goes low.
- R2: Opcode 0x03 takes a 24-bit address on lane 0 with no dummy clocks. It drives data on lane 1 only, with io_oe = 4'b0010. One clock after the last address bit, rd_start pulses for exactly one cycle with rd_addr holding the address.
- R3: Opcode 0x0B behaves like 0x03, except that 8 dummy clocks come between the address and the data.
- R4: Opcode 0x3B takes the address on lane 0, then 8 dummy clocks, then data on two lanes. Bit 7 of each pair goes on lane 1 and bit 6 on lane 0, with io_oe = 4'b0011.
- R5: Opcode 0xBB takes the address on lanes 1:0 (lane 1 carries the higher bit), then 4 dummy clocks, then two-lane data as in R4.
- R6: Opcode 0x6B takes the address on lane 0, then 8 dummy clocks. Opcode 0xEB takes the address on lanes 3:0, then 6 dummy clocks. Both drive data on lanes 3:0 with bit 7 on lane 3, and io_oe = 4'b1111.
- R7: If quad_en is low when the opcode completes, 0x6B and 0xEB are ignored: no rd_start pulse, and io_oe stays zero.
- R8: Output bits change only after falling serial-clock edges. Each byte taken from rd_data produces one rd_next pulse, and successive bytes come from successive addresses.
- R9: The write-type opcodes are 0x06, 0x04, 0x01, 0x02, 0x20, 0xD8, 0xC7 and 0xB9. If the clock count since chip select fell is a nonzero multiple of eight when chip select rises, wr_cmd pulses one cycle with wr_opcode holding the opcode. Otherwise cmd_reject pulses and wr_cmd does not.
- R10: Each complete byte that follows a write-type opcode on lane 0 is presented once on rx_byte with an rx_valid pulse.
- R11: While busy is high at opcode completion, all six read opcodes and 0x02, 0x20, 0xD8 and 0xC7 are ignored: no strobe, no reject and no drive. The other write-type opcodes are still accepted.
- R12: When chip select goes high, io_oe drops in the same cycle and any pending falling edge is discarded. The next selection decodes a fresh opcode from its first bit, even after a partial opcode or an aborted read.
- R13: An unrecognised opcode causes no drive, no rd_start, no wr_cmd and no cmd_reject.
- R14: While reset is low, and after it is released, io_oe is zero and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock, idles low, synchronous to clk |
| io_in | input | 4 | Input values of the four data lanes |
| io_out | output | 4 | Values driven on the data lanes |
| io_oe | output | 4 | Per-lane output enable |
| quad_en | input | 1 | Permits the four-lane read opcodes |
| busy | input | 1 | Internal write cycle in progress |
| rd_start | output | 1 | One-cycle pulse: read address is valid |
| rd_addr | output | ADDR_W | Start address of the current read |
| rd_next | output | 1 | One-cycle pulse: byte on rd_data consumed |
| rd_data | input | 8 | Byte to be shifted out next |
| rx_valid | output | 1 | One-cycle pulse: rx_byte holds a received byte |
| rx_byte | output | 8 | Byte received after a write-type opcode |
| wr_cmd | output | 1 | One-cycle pulse: write-type command accepted |
| wr_opcode | output | 8 | Opcode of the accepted write-type command |
| cmd_reject | output | 1 | One-cycle pulse: write-type command ended off a byte boundary |

## Verification
The case that needs care is chip select rising in the same system-clock cycle as a falling serial-clock edge during a read's output phase. Both the end of the transfer and the loading of the next output byte compete for that cycle. The bench provokes it by raising chip select and lowering the serial clock together in the middle of a data byte. It then judges that the output enables are already off and that the rd_next count shows only the byte taken before the abort. A fresh write-enable command that follows must then be accepted cleanly, which shows the counters were cleared.

// File: rtl/sfe_pkg.sv
// Shared types and opcode table for the serial flash command front end.
// Assumes: byte-wide opcodes; lane widths of 1, 2 or 4 bits per clock.
package sfe_pkg;

    typedef enum logic [1:0] {
        LANE1 = 2'd0,
        LANE2 = 2'd1,
        LANE4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DOUT,
        PH_WDATA,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic       known;
        logic       is_read;
        logic       is_write;
        logic       array;
        logic       quad;
        lane_e      addr_l;
        lane_e      data_l;
        logic [3:0] dummy;
    } cmd_info_t;

    // Maps an opcode to its phase layout and lane widths.
    function automatic cmd_info_t decode_op(input logic [7:0] op);
        cmd_info_t i;
        i = '{known: 1'b0, is_read: 1'b0, is_write: 1'b0, array: 1'b0,
              quad: 1'b0, addr_l: LANE1, data_l: LANE1, dummy: 4'd0};
        case (op)
            8'h03: begin i.known = 1'b1; i.is_read = 1'b1; i.array = 1'b1; end
            8'h0B: begin i.known = 1'b1; i.is_read = 1'b1; i.array = 1'b1; i.dummy = 4'd8; end
            8'h3B: begin i.known = 1'b1; i.is_read = 1'b1; i.array = 1'b1; i.dummy = 4'd8;
                         i.data_l = LANE2; end
            8'hBB: begin i.known = 1'b1; i.is_read = 1'b1; i.array = 1'b1; i.dummy = 4'd4;
                         i.addr_l = LANE2; i.data_l = LANE2; end
            8'h6B: begin i.known = 1'b1; i.is_read = 1'b1; i.array = 1'b1; i.dummy = 4'd8;
                         i.data_l = LANE4; i.quad = 1'b1; end
            8'hEB: begin i.known = 1'b1; i.is_read = 1'b1; i.array = 1'b1; i.dummy = 4'd6;
                         i.addr_l = LANE4; i.data_l = LANE4; i.quad = 1'b1; end
            8'h02, 8'h20, 8'hD8, 8'hC7:
                   begin i.known = 1'b1; i.is_write = 1'b1; i.array = 1'b1; end
            8'h06, 8'h04, 8'h01, 8'hB9:
                   begin i.known = 1'b1; i.is_write = 1'b1; end
            default: ;
        endcase
        return i;
    endfunction

    // Output-enable pattern for a data lane width.
    function automatic logic [3:0] lane_mask(input lane_e l);
        case (l)
            LANE2:   return 4'b0011;
            LANE4:   return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/sfe_edge_det.sv
// Detects serial-clock edges and the rising edge of chip select.
// Assumes: sclk and cs_n are already synchronous to clk and each level
// lasts at least two clk cycles.
module sfe_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise
);
    logic sclk_q;
    logic cs_q;

    // Keeps the previous level of each serial control line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Edges count only while the target is selected; deselect wins.
    always_comb begin
        sclk_rise = sclk & ~sclk_q & ~cs_n;
        sclk_fall = ~sclk & sclk_q & ~cs_n;
        cs_rise   = cs_n & ~cs_q;
    end
endmodule

// File: rtl/sfe_opcode_dec.sv
// Decodes the opcode being completed and decides whether it may proceed.
// Assumes: quad_en and busy are sampled by the caller at opcode completion.
module sfe_opcode_dec
    import sfe_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       quad_en,
    input  logic       busy,
    output cmd_info_t  info,
    output logic       read_ok,
    output logic       write_ok
);
    // Looks up the layout, then applies the quad gate and the busy filter.
    always_comb begin
        info     = decode_op(opcode);
        read_ok  = info.known & info.is_read & (~info.quad | quad_en) & ~busy;
        write_ok = info.known & info.is_write & ~(info.array & busy);
    end
endmodule

// File: rtl/sfe_tx_shift.sv
// Output shifter: on each falling serial-clock edge of the output phase it
// puts the next one, two or four bits on the lanes, reloading from rd_data.
// Assumes: rd_data holds the next byte before the falling edge that needs it.
module sfe_tx_shift
    import sfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       active,
    input  logic       fall,
    input  lane_e      lane,
    input  logic [7:0] rd_data,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic       rd_next
);
    logic [7:0] sreg;
    logic [2:0] nleft;
    logic [3:0] out_bits;
    logic       on;
    logic [7:0] src;
    logic [7:0] src_shift;
    logic [3:0] src_top;
    logic [2:0] reload_left;

    // Chooses the source byte and splits it by lane width.
    always_comb begin
        src = (nleft == 3'd0) ? rd_data : sreg;
        case (lane)
            LANE2: begin
                src_top     = {2'b00, src[7:6]};
                src_shift   = {src[5:0], 2'b00};
                reload_left = 3'd3;
            end
            LANE4: begin
                src_top     = src[7:4];
                src_shift   = {src[3:0], 4'b0000};
                reload_left = 3'd1;
            end
            default: begin
                src_top     = {2'b00, src[7], 1'b0};
                src_shift   = {src[6:0], 1'b0};
                reload_left = 3'd7;
            end
        endcase
    end

    // Advances the shifter on falling edges; deselect clears it.
    always_ff @(posedge clk) begin
        rd_next <= 1'b0;
        if (!rst_n || cs_n || !active) begin
            sreg     <= '0;
            nleft    <= '0;
            out_bits <= '0;
            on       <= 1'b0;
        end else if (fall) begin
            on       <= 1'b1;
            out_bits <= src_top;
            sreg     <= src_shift;
            if (nleft == 3'd0) begin
                nleft   <= reload_left;
                rd_next <= 1'b1;
            end else begin
                nleft <= nleft - 3'd1;
            end
        end
    end

    // Drives the lanes; the enable drops in the same cycle as deselect.
    always_comb begin
        io_out = out_bits;
        io_oe  = (on && !cs_n) ? lane_mask(lane) : 4'b0000;
    end

    p_next_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_next |-> $past(fall));

    p_oe_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'h0) || (io_oe == 4'h2) || (io_oe == 4'h3) || (io_oe == 4'hF));
endmodule

// File: rtl/sfe_cmd_front.sv
// Serial flash command front end: phase controller for opcode, address,
// dummy, output and write-data phases, with byte-boundary checking.
// Assumes: serial mode with sclk idle low; ADDR_W is a multiple of 4.
module sfe_cmd_front
    import sfe_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic              quad_en,
    input  logic              busy,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_next,
    input  logic [7:0]        rd_data,
    output logic              rx_valid,
    output logic [7:0]        rx_byte,
    output logic              wr_cmd,
    output logic [7:0]        wr_opcode,
    output logic              cmd_reject
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(ADDR_W);

    logic              sclk_rise, sclk_fall, cs_rise;
    phase_e            phase;
    logic [CNT_W-1:0]  pcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shift_nx;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] addr_nx;
    cmd_info_t         cur_info;
    cmd_info_t         dec_info;
    logic              read_ok, write_ok;
    logic [CNT_W-1:0]  addr_last;
    logic [CNT_W-1:0]  dummy_last;

    sfe_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise)
    );

    sfe_opcode_dec u_dec (
        .opcode   (shift_nx),
        .quad_en  (quad_en),
        .busy     (busy),
        .info     (dec_info),
        .read_ok  (read_ok),
        .write_ok (write_ok)
    );

    sfe_tx_shift u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .active  (phase == PH_DOUT),
        .fall    (sclk_fall),
        .lane    (cur_info.data_l),
        .rd_data (rd_data),
        .io_out  (io_out),
        .io_oe   (io_oe),
        .rd_next (rd_next)
    );

    // Next serial byte value and next address value at the current lane width.
    always_comb begin
        shift_nx = {shreg[BYTE_W-2:0], io_in[0]};
        case (cur_info.addr_l)
            LANE2:   addr_nx = {addr_sh[ADDR_W-3:0], io_in[1:0]};
            LANE4:   addr_nx = {addr_sh[ADDR_W-5:0], io_in};
            default: addr_nx = {addr_sh[ADDR_W-2:0], io_in[0]};
        endcase
        addr_last  = CNT_W'((ADDR_W >> cur_info.addr_l) - 1);
        dummy_last = CNT_W'(cur_info.dummy) - CNT_W'(1);
    end

    // Phase controller: steps on rising serial edges, clears on deselect.
    always_ff @(posedge clk) begin
        rd_start   <= 1'b0;
        rx_valid   <= 1'b0;
        wr_cmd     <= 1'b0;
        cmd_reject <= 1'b0;
        if (!rst_n) begin
            phase     <= PH_OPC;
            pcnt      <= '0;
            shreg     <= '0;
            addr_sh   <= '0;
            rd_addr   <= '0;
            rx_byte   <= '0;
            wr_opcode <= '0;
            cur_info  <= decode_op(8'h00);
        end else if (cs_n) begin
            if (cs_rise && phase == PH_WDATA) begin
                if (pcnt == '0) begin
                    wr_cmd    <= 1'b1;
                    wr_opcode <= shreg_op_q;
                end else begin
                    cmd_reject <= 1'b1;
                end
            end
            phase <= PH_OPC;
            pcnt  <= '0;
        end else if (sclk_rise) begin
            case (phase)
                PH_OPC: begin
                    shreg <= shift_nx;
                    if (pcnt == CNT_W'(BYTE_W - 1)) begin
                        cur_info <= dec_info;
                        pcnt     <= '0;
                        if (read_ok)       phase <= PH_ADDR;
                        else if (write_ok) phase <= PH_WDATA;
                        else               phase <= PH_IGNORE;
                    end else begin
                        pcnt <= pcnt + CNT_W'(1);
                    end
                end
                PH_ADDR: begin
                    addr_sh <= addr_nx;
                    if (pcnt == addr_last) begin
                        rd_addr  <= addr_nx;
                        rd_start <= 1'b1;
                        pcnt     <= '0;
                        phase    <= (cur_info.dummy != 4'd0) ? PH_DUMMY : PH_DOUT;
                    end else begin
                        pcnt <= pcnt + CNT_W'(1);
                    end
                end
                PH_DUMMY: begin
                    if (pcnt == dummy_last) begin
                        pcnt  <= '0;
                        phase <= PH_DOUT;
                    end else begin
                        pcnt <= pcnt + CNT_W'(1);
                    end
                end
                PH_WDATA: begin
                    shreg <= shift_nx;
                    if (pcnt == CNT_W'(BYTE_W - 1)) begin
                        rx_byte  <= shift_nx;
                        rx_valid <= 1'b1;
                        pcnt     <= '0;
                    end else begin
                        pcnt <= pcnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Holds the opcode of the command in flight for the acceptance strobe.
    logic [BYTE_W-1:0] shreg_op_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg_op_q <= '0;
        else if (!cs_n && sclk_rise && phase == PH_OPC && pcnt == CNT_W'(BYTE_W - 1))
            shreg_op_q <= shift_nx;
    end

    p_oe_in_dout_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_oe) |-> (phase == PH_DOUT && !cs_n));

    p_quad_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_oe[3:2]) |-> cur_info.quad);

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cmd && cmd_reject));

    p_rdstart_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    p_wr_after_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd || cmd_reject) |-> $past(cs_n));
endmodule

// File: tb/sfe_cmd_front_bench.sv
// Directed bench for the serial flash command front end.
module sfe_cmd_front_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, quad_en, busy;
    logic [3:0]  io_in, io_out, io_oe;
    logic        rd_start, rd_next, rx_valid, wr_cmd, cmd_reject;
    logic [23:0] rd_addr;
    logic [7:0]  rd_data, rx_byte, wr_opcode;

    int n_tests = 0;
    int n_fail  = 0;
    int c_wr, c_rej, c_rs, c_rx, c_next;
    logic [7:0]  last_wr_op;
    logic [23:0] last_rd_addr;
    logic [7:0]  rx_log [0:7];
    logic [23:0] ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfe_cmd_front #(.ADDR_W(24)) u_sfe_cmd_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .quad_en(quad_en), .busy(busy),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_next(rd_next), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wr_cmd(wr_cmd), .wr_opcode(wr_opcode), .cmd_reject(cmd_reject)
    );

    function automatic logic [7:0] membyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign rd_data = membyte(ptr);

    // Storage model and strobe monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (rd_start) begin ptr <= rd_addr; c_rs++; last_rd_addr = rd_addr; end
        else if (rd_next) ptr <= ptr + 24'd1;
        if (rd_next) c_next++;
        if (wr_cmd) begin c_wr++; last_wr_op = wr_opcode; end
        if (cmd_reject) c_rej++;
        if (rx_valid) begin
            if (c_rx < 8) rx_log[c_rx] = rx_byte;
            c_rx++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        c_wr = 0; c_rej = 0; c_rs = 0; c_rx = 0; c_next = 0;
    endtask

    task automatic sel();
        cs_n = 1'b0;
        ticks(2);
    endtask

    task automatic desel();
        cs_n  = 1'b1;
        io_in = 4'h0;
        ticks(3);
    endtask

    task automatic clk_in(input logic [3:0] v);
        io_in = v;
        ticks(2);
        sclk = 1'b1;
        ticks(4);
        sclk = 1'b0;
        ticks(2);
    endtask

    task automatic send_bits(input logic [31:0] val, input int nbits, input int lanes);
        for (int i = nbits; i > 0; i -= lanes) begin
            logic [3:0] v;
            v = 4'h0;
            case (lanes)
                2:       v[1:0] = val[i-1 -: 2];
                4:       v      = val[i-1 -: 4];
                default: v[0]   = val[i-1];
            endcase
            clk_in(v);
        end
    endtask

    task automatic clk_out(output logic [3:0] smp, output logic [3:0] oe);
        io_in = 4'h0;
        ticks(2);
        smp = io_out;
        oe  = io_oe;
        sclk = 1'b1;
        ticks(4);
        sclk = 1'b0;
        ticks(2);
    endtask

    task automatic read_test(input string req, input logic [7:0] op, input logic [23:0] a,
                             input int alanes, input int dummy, input int dlanes,
                             input int nbytes, input logic [3:0] exp_oe);
        logic [3:0] smp, oe;
        logic [7:0] got;
        bit oe_ok;
        clr();
        sel();
        send_bits({24'h0, op}, 8, 1);
        send_bits({8'h0, a}, 24, alanes);
        repeat (dummy) clk_in(4'h0);
        chk(c_rs == 1, {req, " rd_start count"}, c_rs, 1);
        chk(last_rd_addr == a, {req, " rd_addr"}, last_rd_addr, a);
        oe_ok = 1'b1;
        for (int b = 0; b < nbytes; b++) begin
            got = 8'h0;
            for (int k = 0; k < 8 / dlanes; k++) begin
                clk_out(smp, oe);
                if (oe != exp_oe) oe_ok = 1'b0;
                case (dlanes)
                    2:       got = {got[5:0], smp[1:0]};
                    4:       got = {got[3:0], smp};
                    default: got = {got[6:0], smp[1]};
                endcase
            end
            chk(got == membyte(a + 24'(b)), {req, " data byte"}, got, membyte(a + 24'(b)));
        end
        chk(oe_ok, {req, " lane enables"}, oe, exp_oe);
        desel();
        chk(c_next == nbytes + 1, {req, " R8 byte requests"}, c_next, nbytes + 1);
        chk(io_oe == 4'h0, {req, " R12 enables off after deselect"}, io_oe, 0);
    endtask

    task automatic read_ignored(input string req, input logic [7:0] op, input int alanes);
        logic [3:0] smp, oe;
        bit quiet;
        clr();
        sel();
        send_bits({24'h0, op}, 8, 1);
        send_bits(32'h00ABCDEF, 24, alanes);
        quiet = 1'b1;
        for (int k = 0; k < 16; k++) begin
            clk_out(smp, oe);
            if (oe != 4'h0) quiet = 1'b0;
        end
        desel();
        chk(c_rs == 0, {req, " no rd_start"}, c_rs, 0);
        chk(quiet, {req, " no lane drive"}, oe, 0);
        chk(c_next == 0 && c_wr == 0 && c_rej == 0, {req, " no strobes"}, c_next + c_wr + c_rej, 0);
    endtask

    task automatic wr_test(input string req, input logic [7:0] op, input logic [31:0] payload,
                           input int nbits, input int exp_ok, input int exp_rej);
        clr();
        sel();
        send_bits({24'h0, op}, 8, 1);
        send_bits(payload, nbits, 1);
        desel();
        chk(c_wr == exp_ok, {req, " wr_cmd count"}, c_wr, exp_ok);
        if (exp_ok != 0) chk(last_wr_op == op, {req, " wr_opcode"}, last_wr_op, op);
        chk(c_rej == exp_rej, {req, " cmd_reject count"}, c_rej, exp_rej);
    endtask

    // R14: idle outputs after reset.
    task automatic t_reset();
        chk(io_oe == 4'h0, "R14 io_oe after reset", io_oe, 0);
        chk({rd_start, rd_next, wr_cmd, cmd_reject, rx_valid} == 5'b0, "R14 strobes after reset",
            {rd_start, rd_next, wr_cmd, cmd_reject, rx_valid}, 0);
    endtask

    // R10: bytes following a page-program opcode.
    task automatic t_program_bytes();
        wr_test("R9 R10 program 4 bytes", 8'h02, 32'h123456A7, 32, 1, 0);
        chk(c_rx == 4, "R10 rx byte count", c_rx, 4);
        chk(rx_log[0] == 8'h12 && rx_log[3] == 8'hA7, "R10 rx byte values",
            {rx_log[0], rx_log[3]}, 16'h12A7);
    endtask

    // R11: busy drops array commands but keeps the others.
    task automatic t_busy();
        busy = 1'b1;
        read_ignored("R11 read while busy", 8'h03, 1);
        wr_test("R11 program while busy", 8'h02, 32'h00000000, 32, 0, 0);
        wr_test("R11 write enable while busy", 8'h06, 32'h0, 0, 1, 0);
        busy = 1'b0;
    endtask

    // R12: deselect coinciding with a falling edge, and partial opcode.
    task automatic t_abort();
        logic [3:0] smp, oe;
        logic [2:0] got;
        clr();
        sel();
        send_bits(32'h03, 8, 1);
        send_bits(32'h00001200, 24, 1);
        got = 3'b0;
        clk_out(smp, oe); got = {got[1:0], smp[1]};
        clk_out(smp, oe); got = {got[1:0], smp[1]};
        io_in = 4'h0;
        ticks(2);
        got = {got[1:0], io_out[1]};
        sclk = 1'b1;
        ticks(4);
        sclk = 1'b0;
        cs_n = 1'b1;
        ticks(1);
        chk(io_oe == 4'h0, "R12 enables off on deselect", io_oe, 0);
        ticks(2);
        chk(got == membyte(24'h001200) >> 5, "R12 partial byte bits", got, membyte(24'h001200) >> 5);
        chk(c_next == 1, "R12 falling edge dropped at deselect", c_next, 1);
        wr_test("R12 command after aborted read", 8'h06, 32'h0, 0, 1, 0);
        clr();
        sel();
        send_bits(32'h15, 5, 1);
        desel();
        chk(c_wr == 0 && c_rej == 0, "R12 partial opcode silent", c_wr + c_rej, 0);
        wr_test("R1 R12 fresh opcode after partial", 8'h04, 32'h0, 0, 1, 0);
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; io_in = 4'h0;
        quad_en = 1'b0; busy = 1'b0; ptr = 24'h0;
        clr();
        ticks(5);
        rst_n = 1'b1;
        ticks(2);
        t_reset();
        read_test("R1 R2 single read", 8'h03, 24'h123456, 1, 0, 1, 3, 4'b0010);
        read_test("R3 fast read", 8'h0B, 24'h00FF10, 1, 8, 1, 2, 4'b0010);
        read_test("R4 dual output read", 8'h3B, 24'hA5A500, 1, 8, 2, 2, 4'b0011);
        read_test("R5 dual io read", 8'hBB, 24'h0F1E2D, 2, 4, 2, 2, 4'b0011);
        read_ignored("R7 quad read gated", 8'h6B, 1);
        read_ignored("R7 quad io gated", 8'hEB, 4);
        quad_en = 1'b1;
        read_test("R6 quad output read", 8'h6B, 24'h334455, 1, 8, 4, 3, 4'b1111);
        read_test("R6 R8 quad io read", 8'hEB, 24'h7788FE, 4, 6, 4, 3, 4'b1111);
        quad_en = 1'b0;
        wr_test("R9 write enable", 8'h06, 32'h0, 0, 1, 0);
        wr_test("R9 sector erase on boundary", 8'h20, 32'h00010000, 24, 1, 0);
        wr_test("R9 sector erase off boundary", 8'h20, 32'h00080005, 27, 0, 1);
        wr_test("R9 power down extra bit", 8'hB9, 32'h1, 1, 0, 1);
        t_program_bytes();
        t_busy();
        read_ignored("R13 unknown opcode", 8'hFF, 1);
        wr_test("R13 unknown opcode no strobe", 8'h5A, 32'h0, 0, 0, 0);
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule